// File: doc/BRIEF.md
# Quad-Rail Supply Supervisor Controller

This block holds the digital decision and timing logic of a supervisor that watches four supply rails. For every rail an analog front end supplies two comparator flags: one that rises when the upper divider tap drops below its threshold, and one that rises when the lower tap climbs above its threshold. The block decides whether each flag means undervoltage or overvoltage. That meaning depends on the rail polarity set by a three-state select. The block rejects short transients and combines the faults into two active-low outputs. Each output stays asserted for a programmable hold time after the faults clear.

A build-time variant sets the meaning of one mode pin. In the latching variant the pin controls whether an overvoltage event is held until software-free clearing by driving the pin high. In the disabling variant the pin forces both outputs inactive. Supply lockout overrides everything: it asserts the undervoltage output and suppresses the overvoltage output. A synchronous reset puts the block in the same state as lockout.

Top module: `supply_supervisor_ctrl`

## Requirements
- R1: Rails 1 and 2 are always positive. On these rails the high-side-below flag is an undervoltage fault and the low-side-above flag is an overvoltage fault.
- R2: The select `pol_sel_i` sets the polarity of rails 3 and 4. Rail 3 is negative only for code 2'b00. Rail 4 is negative for codes 2'b00 and 2'b10. Codes 2'b01 and 2'b11 make both rails positive. On a negative rail the two flag meanings swap: low-side-above means undervoltage and high-side-below means overvoltage.
- R3: A flag counts as a fault only after its synchronized value has been high for `FILT_CYCLES` consecutive clocks. A shorter pulse has no effect on either output.
- R4: `uv_n_o` is low while any rail has an undervoltage fault, and `ov_n_o` is low while any rail has an overvoltage fault. After the last fault of a type clears, that output stays low for `HOLD_CYCLES` further clocks. A new fault of the same type during this hold restarts the hold.
- R5: While `timer_bypass_i` is high, an output releases one clock after its faults clear, with no hold period.
- R6: While `supply_ok_i` is low (lockout), `uv_n_o` is low and `ov_n_o` is high. Any pending overvoltage hold or latch is cleared.
- R7: During and right after reset, `uv_n_o` is low and `ov_n_o` is high. After reset or lockout ends, `uv_n_o` releases only when a full hold period has elapsed, the same as after a cleared undervoltage.
- R8: Latching variant, mode pin low: once `ov_n_o` goes low it stays low after the fault and hold have ended. It stays low until the mode pin goes high or lockout occurs.
- R9: Latching variant, mode pin high: the latch is cleared and `ov_n_o` follows the same hold behaviour as `uv_n_o`. If the pin drops low while the overvoltage hold is still running, `ov_n_o` becomes latched low.
- R10: Disabling variant, mode pin high: both outputs are high regardless of faults. Lockout still drives `uv_n_o` low, and `uv_n_o` releases as soon as lockout ends, with no hold period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_below_i | input | 4 | Per-rail flag: upper tap below threshold (asynchronous) |
| lo_above_i | input | 4 | Per-rail flag: lower tap above threshold (asynchronous) |
| supply_ok_i | input | 1 | Supply valid; low means lockout (asynchronous) |
| pol_sel_i | input | 2 | Polarity code for rails 3 and 4 (static strap) |
| timer_bypass_i | input | 1 | Skip the hold period (static strap) |
| mode_i | input | 1 | Latch control or global disable, by variant (asynchronous) |
| uv_n_o | output | 1 | Undervoltage indication, active low |
| ov_n_o | output | 1 | Overvoltage indication, active low |

## Verification
The bench builds two copies of the block, one of each variant, with `FILT_CYCLES` = 3 and `HOLD_CYCLES` = 20. These values are short enough that it can time a release to within a few clocks of the expected edge. They also let a two-clock pulse be rejected while a three-clock pulse is accepted. Because the hold is short, a restarted hold can be told apart from an uninterrupted one, and a latch can be seen to outlive its hold. Running both variants side by side exercises the disable override and its lockout exception on the same stimulus that drives the latch tests.

// File: rtl/sup_ctrl_pkg.sv
// Package: shared types and polarity decoding for the supply supervisor controller.
// Assumes the polarity strap is a static 2-bit code from a three-state pad decoder.
package sup_ctrl_pkg;

    localparam int unsigned RAILS = 4;

    // Pad decoder codes for the three-state polarity strap.
    typedef enum logic [1:0] {
        SEL_TIED_LOW  = 2'b00,
        SEL_TIED_HIGH = 2'b01,
        SEL_FLOATING  = 2'b10,
        SEL_SPARE     = 2'b11
    } pol_sel_e;

    // Build-time meaning of the mode pin.
    typedef enum logic {
        VAR_LATCH   = 1'b0,
        VAR_DISABLE = 1'b1
    } variant_e;

    // Returns 1 when rail index idx (0-based) is configured as negative.
    function automatic logic rail_negative(input logic [1:0] sel, input int idx);
        logic neg;
        case (idx)
            2:       neg = (sel == SEL_TIED_LOW);
            3:       neg = (sel == SEL_TIED_LOW) || (sel == SEL_FLOATING);
            default: neg = 1'b0;
        endcase
        return neg;
    endfunction

endpackage

// File: rtl/sup_sync2.sv
// Module: two-flop synchronizer for a vector of asynchronous level signals.
// Assumes each bit is an independent slow level; no bus coherency is implied.
module sup_sync2 #(
    parameter int unsigned W           = 1,
    parameter logic [W-1:0] RESET_VALUE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Purpose: two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RESET_VALUE;
            stage2_q <= RESET_VALUE;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/sup_glitch_filter.sv
// Module: persistence filter. The output rises only after the input has been
// high on FILT_CYCLES consecutive clocks, and falls one clock after the input drops.
// Assumes the input is already synchronous to clk.
module sup_glitch_filter #(
    parameter int unsigned FILT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic hit_o
);
    localparam int unsigned LIMIT = FILT_CYCLES - 1;
    localparam int unsigned CW    = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;

    logic [CW-1:0] run_q;
    logic          hit_q;

    // Purpose: count consecutive high samples and saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!level_i) begin
            run_q <= '0;
        end else if (run_q < CW'(LIMIT)) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Purpose: declare a fault once the run of high samples is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= level_i && (run_q >= CW'(LIMIT));
        end
    end

    assign hit_o = hit_q;
endmodule

// File: rtl/sup_fault_map.sv
// Module: maps filtered comparator flags to undervoltage and overvoltage faults
// according to rail polarity, and ORs them across rails.
// Assumes the polarity code is static while faults are being evaluated.
module sup_fault_map #(
    parameter int unsigned RAILS = sup_ctrl_pkg::RAILS
) (
    input  logic [RAILS-1:0] hi_hit_i,
    input  logic [RAILS-1:0] lo_hit_i,
    input  logic [1:0]       pol_sel_i,
    output logic             uv_any_o,
    output logic             ov_any_o
);
    logic [RAILS-1:0] uv_vec;
    logic [RAILS-1:0] ov_vec;

    for (genvar r = 0; r < RAILS; r++) begin : g_rail
        logic neg;
        // Purpose: swap the flag meanings on a negative rail.
        assign neg       = sup_ctrl_pkg::rail_negative(pol_sel_i, r);
        assign uv_vec[r] = neg ? lo_hit_i[r] : hi_hit_i[r];
        assign ov_vec[r] = neg ? hi_hit_i[r] : lo_hit_i[r];
    end

    assign uv_any_o = |uv_vec;
    assign ov_any_o = |ov_vec;
endmodule

// File: rtl/sup_hold_timer.sv
// Module: restartable hold stretcher. The output is active while the fault is
// present and for HOLD_CYCLES clocks after it clears. The count restarts on any
// new fault. Bypass releases one clock after clear, and force_clr drops everything.
// Assumes the fault input is synchronous.
module sup_hold_timer #(
    parameter int unsigned HOLD_CYCLES  = 1000,
    parameter logic        RESET_ACTIVE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic bypass_i,
    input  logic force_clr_i,
    output logic active_o
);
    localparam int unsigned LIMIT = HOLD_CYCLES - 1;
    localparam int unsigned CW    = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

    logic [CW-1:0] cnt_q;
    logic          active_q;

    // Purpose: assert on fault, count down the hold after clear, release at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= RESET_ACTIVE;
            cnt_q    <= '0;
        end else if (force_clr_i) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (fault_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (bypass_i || (cnt_q == CW'(LIMIT))) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
endmodule

// File: rtl/supply_supervisor_ctrl.sv
// Module: decision and timing logic of a four-rail UV/OV supervisor.
// It synchronizes and filters comparator flags, maps them to fault types by
// polarity, stretches each output by a restartable hold, and applies lockout
// and the variant-specific mode pin (overvoltage latch or global disable).
// Assumes pol_sel_i and timer_bypass_i are static straps.
module supply_supervisor_ctrl #(
    parameter int unsigned           FILT_CYCLES = 3,
    parameter int unsigned           HOLD_CYCLES = 1000,
    parameter sup_ctrl_pkg::variant_e VARIANT    = sup_ctrl_pkg::VAR_LATCH
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] hi_below_i,
    input  logic [3:0] lo_above_i,
    input  logic       supply_ok_i,
    input  logic [1:0] pol_sel_i,
    input  logic       timer_bypass_i,
    input  logic       mode_i,
    output logic       uv_n_o,
    output logic       ov_n_o
);
    import sup_ctrl_pkg::*;

    localparam int unsigned NFLAG = 2 * RAILS;

    logic [NFLAG-1:0] flag_s;
    logic [NFLAG-1:0] flag_hit;
    logic [1:0]       ctrl_s;
    logic             supply_ok_s;
    logic             mode_s;
    logic             lockout_s;
    logic             dis_s;
    logic             uv_map;
    logic             ov_map;
    logic             uv_fault_w;
    logic             ov_fault_w;
    logic             uv_active;
    logic             ov_active;
    logic             ov_latch_q;

    // Purpose: bring comparator flags into the clock domain.
    sup_sync2 #(.W(NFLAG), .RESET_VALUE('0)) u_sync_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({lo_above_i, hi_below_i}),
        .sync_o  (flag_s)
    );

    // Purpose: bring supply-valid and mode into the clock domain; reset reads as lockout.
    sup_sync2 #(.W(2), .RESET_VALUE(2'b00)) u_sync_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({supply_ok_i, mode_i}),
        .sync_o  (ctrl_s)
    );

    assign supply_ok_s = ctrl_s[1];
    assign mode_s      = ctrl_s[0];
    assign lockout_s   = !supply_ok_s;
    assign dis_s       = (VARIANT == VAR_DISABLE) && mode_s;

    // Purpose: one persistence filter per comparator flag.
    for (genvar f = 0; f < NFLAG; f++) begin : g_filt
        sup_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (flag_s[f]),
            .hit_o   (flag_hit[f])
        );
    end

    sup_fault_map #(.RAILS(RAILS)) u_map (
        .hi_hit_i  (flag_hit[RAILS-1:0]),
        .lo_hit_i  (flag_hit[NFLAG-1:RAILS]),
        .pol_sel_i (pol_sel_i),
        .uv_any_o  (uv_map),
        .ov_any_o  (ov_map)
    );

    // Purpose: lockout counts as an undervoltage and masks overvoltage.
    assign uv_fault_w = uv_map || lockout_s;
    assign ov_fault_w = ov_map && !lockout_s;

    sup_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES), .RESET_ACTIVE(1'b1)) u_uv_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_i     (uv_fault_w),
        .bypass_i    (timer_bypass_i || dis_s),
        .force_clr_i (1'b0),
        .active_o    (uv_active)
    );

    sup_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES), .RESET_ACTIVE(1'b0)) u_ov_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_i     (ov_fault_w),
        .bypass_i    (timer_bypass_i || dis_s),
        .force_clr_i (lockout_s),
        .active_o    (ov_active)
    );

    // Purpose: hold the overvoltage indication in the latching variant while mode is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_latch_q <= 1'b0;
        end else if (lockout_s || mode_s || (VARIANT != VAR_LATCH)) begin
            ov_latch_q <= 1'b0;
        end else if (ov_active) begin
            ov_latch_q <= 1'b1;
        end
    end

    assign uv_n_o = !(lockout_s || (uv_active && !dis_s));
    assign ov_n_o = !((ov_active || ov_latch_q) && !dis_s && !lockout_s);
endmodule

// File: rtl/sup_ctrl_checker.sv
// Module: assertion checker for supply_supervisor_ctrl, attached by bind.
// Assumes the internal fault, lockout and mode signals of the top are visible by name.
module sup_ctrl_checker #(
    parameter sup_ctrl_pkg::variant_e VARIANT = sup_ctrl_pkg::VAR_LATCH
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok_i,
    input logic uv_n_o,
    input logic ov_n_o,
    input logic uv_fault_w,
    input logic dis_s,
    input logic lockout_s,
    input logic mode_s
);
    import sup_ctrl_pkg::*;

    // R6: two clocks after supply-valid is low, UV is asserted and OV is not.
    p_lockout_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(supply_ok_i, 2) |-> (!uv_n_o && ov_n_o));

    // R4: an undervoltage fault drives UV low on the next clock unless disabled.
    p_uv_follows_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_fault_w && !dis_s) |=> (!uv_n_o || dis_s));

    // R4: UV never releases in a clock that still had an undervoltage fault.
    p_uv_release_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(uv_n_o) && !dis_s) |-> !$past(uv_fault_w));

    // R8: in the latching variant an asserted OV stays low while mode is low.
    p_ov_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((VARIANT == VAR_LATCH) && !ov_n_o && !mode_s && !lockout_s)
        |=> (!ov_n_o || mode_s || lockout_s));

    // R10: in the disabling variant both outputs are high outside lockout.
    p_disable_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((VARIANT == VAR_DISABLE) && dis_s && !lockout_s) |-> (uv_n_o && ov_n_o));
endmodule

bind supply_supervisor_ctrl sup_ctrl_checker #(.VARIANT(VARIANT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok_i (supply_ok_i),
    .uv_n_o      (uv_n_o),
    .ov_n_o      (ov_n_o),
    .uv_fault_w  (uv_fault_w),
    .dis_s       (dis_s),
    .lockout_s   (lockout_s),
    .mode_s      (mode_s)
);

// File: tb/tb_supply_supervisor_ctrl.sv
// Scoreboard bench: the driver pushes expected output pairs into a queue, and a
// monitor at the falling edge pops and compares them with both instances.
`timescale 1ns/1ps
module tb_supply_supervisor_ctrl;
    localparam int unsigned FILT = 3;
    localparam int unsigned HOLD = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] hi_below;
    logic [3:0] lo_above;
    logic       supply_ok;
    logic [1:0] pol_sel;
    logic       bypass;
    logic       mode_l;
    logic       mode_d;
    logic       uv_n_l, ov_n_l, uv_n_d, ov_n_d;

    always #2.5 clk = ~clk;

    supply_supervisor_ctrl #(.FILT_CYCLES(FILT), .HOLD_CYCLES(HOLD),
                             .VARIANT(sup_ctrl_pkg::VAR_LATCH)) dut (
        .clk(clk), .rst_n(rst_n), .hi_below_i(hi_below), .lo_above_i(lo_above),
        .supply_ok_i(supply_ok), .pol_sel_i(pol_sel), .timer_bypass_i(bypass),
        .mode_i(mode_l), .uv_n_o(uv_n_l), .ov_n_o(ov_n_l));

    supply_supervisor_ctrl #(.FILT_CYCLES(FILT), .HOLD_CYCLES(HOLD),
                             .VARIANT(sup_ctrl_pkg::VAR_DISABLE)) dut_dis (
        .clk(clk), .rst_n(rst_n), .hi_below_i(hi_below), .lo_above_i(lo_above),
        .supply_ok_i(supply_ok), .pol_sel_i(pol_sel), .timer_bypass_i(bypass),
        .mode_i(mode_d), .uv_n_o(uv_n_d), .ov_n_o(ov_n_d));

    typedef struct {
        int    which;
        logic  uv_n;
        logic  ov_n;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   finished = 0;

    // Monitor: pop each expected item and compare against the chosen instance.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            automatic exp_t e = sb_q.pop_front();
            automatic logic au = (e.which == 0) ? uv_n_l : uv_n_d;
            automatic logic ao = (e.which == 0) ? ov_n_l : ov_n_d;
            n_vec++;
            if (au !== e.uv_n || ao !== e.ov_n) begin
                n_bad++;
                $display("FAIL %s inst%0d: uv_n/ov_n actual %b%b expected %b%b",
                         e.tag, e.which, au, ao, e.uv_n, e.ov_n);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input int which, input logic uv, input logic ov, input string tag);
        exp_t e;
        e.which = which; e.uv_n = uv; e.ov_n = ov; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one miscompare.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; hi_below = '0; lo_above = '0; supply_ok = 1'b1;
        pol_sel = 2'b01; bypass = 1'b0; mode_l = 1'b1; mode_d = 1'b0;
        step(4);
        expect_out(0, 1'b0, 1'b1, "R7 reset state latch inst");
        expect_out(1, 1'b0, 1'b1, "R7 reset state disable inst");
        rst_n = 1'b1;
        step(10);
        expect_out(0, 1'b0, 1'b1, "R7 hold after reset");
        step(HOLD + 2);
        expect_out(0, 1'b1, 1'b1, "R7 release after reset hold");

        // R1: positive rail mapping on rails 1 and 2
        hi_below[0] = 1'b1; step(10);
        expect_out(0, 1'b0, 1'b1, "R1 rail1 high-side is UV");
        hi_below[0] = 1'b0; lo_above[1] = 1'b1; step(10);
        expect_out(0, 1'b0, 1'b0, "R1 rail2 low-side is OV");
        lo_above[1] = 1'b0; step(HOLD + 10);
        expect_out(0, 1'b1, 1'b1, "R4 both released after hold");

        // R4: exact hold length
        hi_below[2] = 1'b1; step(10);
        hi_below[2] = 1'b0; step(HOLD);
        expect_out(0, 1'b0, 1'b1, "R4 still held before hold ends");
        step(6);
        expect_out(0, 1'b1, 1'b1, "R4 released after hold");

        // R4: restart on new fault during hold
        hi_below[1] = 1'b1; step(10);
        hi_below[1] = 1'b0; step(10);
        hi_below[3] = 1'b1; step(6);
        hi_below[3] = 1'b0; step(HOLD);
        expect_out(0, 1'b0, 1'b1, "R4 hold restarted by second fault");
        step(8);
        expect_out(0, 1'b1, 1'b1, "R4 release after restarted hold");

        // R3: glitch rejection
        hi_below[0] = 1'b1; step(FILT - 1);
        hi_below[0] = 1'b0; step(10);
        expect_out(0, 1'b1, 1'b1, "R3 short pulse ignored");
        hi_below[0] = 1'b1; step(FILT);
        hi_below[0] = 1'b0; step(8);
        expect_out(0, 1'b0, 1'b1, "R3 pulse of filter length accepted");
        step(HOLD + 6);

        // R5: bypass strap
        bypass = 1'b1;
        lo_above[0] = 1'b1; step(10);
        expect_out(0, 1'b1, 1'b0, "R5 OV asserted with bypass");
        lo_above[0] = 1'b0; step(8);
        expect_out(0, 1'b1, 1'b1, "R5 OV released at once with bypass");

        // R2: polarity decoding on rails 3 and 4
        pol_sel = 2'b00;
        lo_above[2] = 1'b1; step(10);
        expect_out(0, 1'b0, 1'b1, "R2 sel00 rail3 low-side is UV");
        lo_above[2] = 1'b0; step(8);
        hi_below[3] = 1'b1; step(10);
        expect_out(0, 1'b1, 1'b0, "R2 sel00 rail4 high-side is OV");
        hi_below[3] = 1'b0; step(8);
        pol_sel = 2'b10;
        lo_above[2] = 1'b1; step(10);
        expect_out(0, 1'b1, 1'b0, "R2 sel10 rail3 positive");
        lo_above[2] = 1'b0; step(8);
        lo_above[3] = 1'b1; step(10);
        expect_out(0, 1'b0, 1'b1, "R2 sel10 rail4 negative");
        lo_above[3] = 1'b0; step(8);
        pol_sel = 2'b11;
        lo_above[3] = 1'b1; step(10);
        expect_out(0, 1'b1, 1'b0, "R2 sel11 treated as tied high");
        lo_above[3] = 1'b0; step(8);
        pol_sel = 2'b01;
        expect_out(0, 1'b1, 1'b1, "R2 idle after polarity tests");
        bypass = 1'b0;

        // R6 and R7: lockout
        lo_above[0] = 1'b1; step(10);
        supply_ok = 1'b0; step(4);
        expect_out(0, 1'b0, 1'b1, "R6 lockout forces UV and blocks OV");
        expect_out(1, 1'b0, 1'b1, "R6 lockout disable inst");
        lo_above[0] = 1'b0; step(6);
        supply_ok = 1'b1; step(8);
        expect_out(0, 1'b0, 1'b1, "R7 UV hold runs after lockout");
        step(HOLD);
        expect_out(0, 1'b1, 1'b1, "R7 release after lockout hold");

        // R8: latching with mode low
        mode_l = 1'b0; step(4);
        lo_above[0] = 1'b1; step(10);
        expect_out(0, 1'b1, 1'b0, "R8 OV asserted");
        lo_above[0] = 1'b0; step(HOLD + 10);
        expect_out(0, 1'b1, 1'b0, "R8 OV stays latched");
        expect_out(1, 1'b1, 1'b1, "R8 disable inst not latched");

        // R9: mode high clears and behaves like UV
        mode_l = 1'b1; step(4);
        expect_out(0, 1'b1, 1'b1, "R9 latch cleared by mode high");
        lo_above[0] = 1'b1; step(10);
        lo_above[0] = 1'b0; step(HOLD);
        expect_out(0, 1'b1, 1'b0, "R9 OV held like UV");
        step(6);
        expect_out(0, 1'b1, 1'b1, "R9 OV released after hold");
        lo_above[0] = 1'b1; step(10);
        lo_above[0] = 1'b0; step(8);
        mode_l = 1'b0; step(HOLD + 6);
        expect_out(0, 1'b1, 1'b0, "R9 mode low during hold latches");
        mode_l = 1'b1; step(4);
        expect_out(0, 1'b1, 1'b1, "R9 latch cleared again");

        // R10: disable variant
        mode_d = 1'b1; step(4);
        hi_below[0] = 1'b1; lo_above[1] = 1'b1; step(10);
        expect_out(1, 1'b1, 1'b1, "R10 disable overrides faults");
        expect_out(0, 1'b0, 1'b0, "R10 latch inst sees faults");
        hi_below[0] = 1'b0; lo_above[1] = 1'b0; step(HOLD + 8);
        supply_ok = 1'b0; step(4);
        expect_out(1, 1'b0, 1'b1, "R10 lockout still asserts UV");
        supply_ok = 1'b1; step(4);
        expect_out(1, 1'b1, 1'b1, "R10 UV released at lockout end");
        mode_d = 1'b0; step(4);
        expect_out(1, 1'b1, 1'b1, "R10 idle after disable removed");

        step(2);
        finish_run();
    end
endmodule